// File: doc/BRIEF.md
# SPI Output Latch with Fault Readback

This block is the serial front end of an eight-channel output switch controller. An SPI master pulls the select line low and clocks a command frame in. Each falling select edge takes a snapshot of the fault flags, and the block shifts that snapshot out while the command frame shifts in. When select rises, the last bits received become the new output drive word. A strap input sets the frame to 8 or 16 bits. Bits clocked in beyond the frame length come out again behind the fault bits, so several of these blocks can share one chain.

All serial pins are resynchronised into the system clock, and every action follows an edge detected there. Fault inputs are synchronous levels that latch until the next select falling edge.

An active-low drive-enable pin forces every output off once it has stayed low for a qualification time. While it is low, the fault flags and the serial readback keep working. Outputs come back only after the pin returns high, a setup time has passed, and a fresh frame is written.

Top module: `spi_outlatch`

## Requirements
- R1: After reset, `drive` is 0, `spi_miso_oe` and `spi_miso` are 0, and the fault latch is empty, so the first snapshot holds only the faults present at that time.
- R2: `spi_miso_oe` is 1 only while `spi_sel_n` is low, and bits are counted and shifted only while it is low.
- R3: On a select falling edge, the snapshot (latched faults OR current faults) is loaded. It leaves `spi_miso` MSB first, `fault_in[7]` first. In 16-bit mode, eight zero bits follow it.
- R4: A fault bit that is high in any cycle between two select falling edges appears in the snapshot taken at the second edge. At each falling edge the latch is reloaded with only the faults present in that cycle.
- R5: On a select rising edge of a complete frame, `drive` takes the last eight bits received. The last bit received goes to `drive[0]`. In 16-bit mode, the first eight bits of the frame (the reserved byte) have no effect.
- R6: With `long_frame` at 0 the frame is 8 bits, and with it at 1 the frame is 16 bits.
- R7: When more bits than the frame length are sent, only the last frame-length bits count. The earlier bits leave `spi_miso` after the snapshot, in the order they were sent.
- R8: A frame with fewer bits than the frame length is dropped, and `drive` keeps its value.
- R9: Once `drive_ena_n` has been low for `QUAL_CYC` consecutive cycles, `drive` goes to 0. A shorter low pulse leaves `drive` unchanged.
- R10: A frame is dropped if it ends while `drive_ena_n` is low, or within `SETUP_CYC` cycles after reset or after `drive_ena_n` returns high. After a forced-off, `drive` stays 0 until a frame is accepted.
- R11: While `drive_ena_n` is low, the fault snapshot still reads back correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_clk | input | 1 | Serial clock, mode 0 |
| spi_sel_n | input | 1 | Active-low select |
| spi_mosi | input | 1 | Serial data in, sampled on rising spi_clk |
| long_frame | input | 1 | 0: 8-bit frame, 1: 16-bit frame |
| drive_ena_n | input | 1 | Active-low enable for all outputs |
| fault_in | input | OUT_W | Synchronous fault flags |
| spi_miso | output | 1 | Serial data out, changes after falling spi_clk |
| spi_miso_oe | output | 1 | Output enable for the spi_miso pad |
| drive | output | OUT_W | Output drive word |

## Verification
The assertions check on every cycle the behaviours that are timing rules:
- the SDO pad is enabled only while selected and always enabled when selected;
- `drive` changes only while deselected or when it drops to zero;
- a long enough drive-enable low forces `drive` to zero;
- `drive` never leaves zero while the enable is held low;
- the outputs are clean after reset.

Only the bench's scenarios can show the data-dependent behaviours: the bit order of the readback, the pass-through of extra bits, the sticky fault latch, dropped short frames, the reserved byte being ignored, and the setup window before frames are accepted again.

// File: rtl/spi_outlatch_pkg.sv
package spi_outlatch_pkg;

  typedef struct packed {
    logic sck;
    logic cs_n;
    logic sdi;
    logic mode;
    logic oe_n;
  } pin_bundle_t;

  localparam pin_bundle_t PIN_IDLE = '{sck: 1'b0, cs_n: 1'b1, sdi: 1'b0, mode: 1'b0, oe_n: 1'b1};

  typedef enum logic {
    FRAME_SHORT = 1'b0,
    FRAME_LONG  = 1'b1
  } frame_len_e;

endpackage

// File: rtl/sol_sync.sv
module sol_sync #(
  parameter int              W      = 1,
  parameter int              STAGES = 2,
  parameter logic [W-1:0]    INIT   = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[i] <= INIT;
          else     stage_q[i] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[i] <= INIT;
          else     stage_q[i] <= stage_q[i-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/sol_fault_latch.sv
module sol_fault_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] fault_in,
  input  logic         take,
  output logic [W-1:0] snap
);

  logic [W-1:0] held_q;

  // Snapshot includes the current cycle so a fault arriving with the edge is not lost.
  assign snap = held_q | fault_in;

  always_ff @(posedge clk) begin
    if (rst)       held_q <= '0;
    else if (take) held_q <= fault_in;   // cleared after copy, refilled by faults still present
    else           held_q <= held_q | fault_in;
  end

endmodule

// File: rtl/sol_shifter.sv
module sol_shifter #(
  parameter int OUT_W     = 8,
  parameter int SHORT_LEN = 8,
  parameter int LONG_LEN  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel,
  input  logic             cs_fall,
  input  logic             sck_rise,
  input  logic             sck_fall,
  input  logic             sdi,
  input  logic             long_mode,
  input  logic [OUT_W-1:0] snap,
  output logic [OUT_W-1:0] cmd,
  output logic             full,
  output logic             miso,
  output logic             miso_en
);

  localparam int CNT_W = $clog2(LONG_LEN + 1);

  logic [LONG_LEN-1:0] sr_q;
  logic [CNT_W-1:0]    cnt_q;
  logic                bit_q;
  logic                miso_q;
  logic                men_q;
  logic                tap;

  function automatic logic [LONG_LEN-1:0] load_word(input logic lm, input logic [OUT_W-1:0] s);
    logic [LONG_LEN-1:0] v;
    v = '0;
    if (lm) v[LONG_LEN-1 -: OUT_W]  = s;
    else    v[SHORT_LEN-1 -: OUT_W] = s;
    return v;
  endfunction

  assign tap  = long_mode ? sr_q[LONG_LEN-1] : sr_q[SHORT_LEN-1];
  assign cmd  = sr_q[OUT_W-1:0];
  assign full = long_mode ? (cnt_q >= CNT_W'(LONG_LEN)) : (cnt_q >= CNT_W'(SHORT_LEN));
  assign miso    = miso_q;
  assign miso_en = men_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q   <= '0;
      cnt_q  <= '0;
      bit_q  <= 1'b0;
      miso_q <= 1'b0;
      men_q  <= 1'b0;
    end else begin
      men_q  <= sel;
      miso_q <= sel ? tap : 1'b0;
      if (cs_fall) begin
        sr_q  <= load_word(long_mode, snap);
        cnt_q <= '0;
      end else if (sel) begin
        if (sck_rise) begin
          bit_q <= sdi;
          if (cnt_q != CNT_W'(LONG_LEN)) cnt_q <= cnt_q + 1'b1;
        end
        if (sck_fall) sr_q <= {sr_q[LONG_LEN-2:0], bit_q};
      end
    end
  end

endmodule

// File: rtl/sol_oe_ctl.sv
module sol_oe_ctl #(
  parameter int QUAL  = 16,
  parameter int SETUP = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic oe_n_s,
  output logic kill,
  output logic ready
);

  localparam int QW = $clog2(QUAL + 1);
  localparam int SW = $clog2(SETUP + 1);

  logic [QW-1:0] qcnt_q;
  logic [SW-1:0] scnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      qcnt_q <= '0;
      kill   <= 1'b0;
    end else begin
      kill <= 1'b0;
      if (oe_n_s) begin
        qcnt_q <= '0;
      end else if (qcnt_q != QW'(QUAL)) begin
        qcnt_q <= qcnt_q + 1'b1;
        if (qcnt_q == QW'(QUAL - 1)) kill <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scnt_q <= '0;
      ready  <= 1'b0;
    end else if (!oe_n_s) begin
      scnt_q <= '0;
      ready  <= 1'b0;
    end else if (scnt_q != SW'(SETUP)) begin
      scnt_q <= scnt_q + 1'b1;
      ready  <= (scnt_q == SW'(SETUP - 1));
    end
  end

endmodule

// File: rtl/spi_outlatch.sv
module spi_outlatch
  import spi_outlatch_pkg::*;
#(
  parameter int OUT_W       = 8,
  parameter int SHORT_LEN   = 8,
  parameter int LONG_LEN    = 16,
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_CYC    = 16,
  parameter int SETUP_CYC   = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             spi_clk,
  input  logic             spi_sel_n,
  input  logic             spi_mosi,
  input  logic             long_frame,
  input  logic             drive_ena_n,
  input  logic [OUT_W-1:0] fault_in,
  output logic             spi_miso,
  output logic             spi_miso_oe,
  output logic [OUT_W-1:0] drive
);

  localparam int PIN_W = $bits(pin_bundle_t);

  pin_bundle_t raw, syn, prev_q;
  frame_len_e  len_sel;
  logic sck_rise, sck_fall, cs_fall, cs_rise, sel;
  logic [OUT_W-1:0] snap, cmd;
  logic full, kill, ready;
  logic [OUT_W-1:0] drive_q;

  assign raw = '{sck: spi_clk, cs_n: spi_sel_n, sdi: spi_mosi, mode: long_frame, oe_n: drive_ena_n};

  sol_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .INIT(PIN_IDLE)) u_sync (
    .clk(clk), .rst(rst), .d(raw), .q(syn)
  );

  always_ff @(posedge clk) begin
    if (rst) prev_q <= PIN_IDLE;
    else     prev_q <= syn;
  end

  assign sck_rise = syn.sck & ~prev_q.sck;
  assign sck_fall = ~syn.sck & prev_q.sck;
  assign cs_fall  = ~syn.cs_n & prev_q.cs_n;
  assign cs_rise  = syn.cs_n & ~prev_q.cs_n;
  assign sel      = ~syn.cs_n;
  assign len_sel  = frame_len_e'(syn.mode);

  sol_fault_latch #(.W(OUT_W)) u_flt (
    .clk(clk), .rst(rst), .fault_in(fault_in), .take(cs_fall), .snap(snap)
  );

  sol_shifter #(.OUT_W(OUT_W), .SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN)) u_shf (
    .clk(clk), .rst(rst), .sel(sel), .cs_fall(cs_fall), .sck_rise(sck_rise),
    .sck_fall(sck_fall), .sdi(syn.sdi), .long_mode(len_sel == FRAME_LONG),
    .snap(snap), .cmd(cmd), .full(full), .miso(spi_miso), .miso_en(spi_miso_oe)
  );

  sol_oe_ctl #(.QUAL(QUAL_CYC), .SETUP(SETUP_CYC)) u_oe (
    .clk(clk), .rst(rst), .oe_n_s(syn.oe_n), .kill(kill), .ready(ready)
  );

  // Forced-off wins over a commit in the same cycle.
  always_ff @(posedge clk) begin
    if (rst)                            drive_q <= '0;
    else if (kill)                      drive_q <= '0;
    else if (cs_rise && full && ready)  drive_q <= cmd;
  end

  assign drive = drive_q;

endmodule

// File: rtl/sol_chk.sv
module sol_chk #(
  parameter int OUT_W = 8,
  parameter int QUAL  = 16,
  parameter int SYNC  = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             spi_sel_n,
  input logic             drive_ena_n,
  input logic             spi_miso,
  input logic             spi_miso_oe,
  input logic [OUT_W-1:0] drive
);

  logic [15:0] hi_cnt, lo_cnt, oe_cnt;
  logic        rst_q;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) begin
      hi_cnt <= '0; lo_cnt <= '0; oe_cnt <= '0;
    end else begin
      hi_cnt <= !spi_sel_n ? '0 : (hi_cnt == 16'hFFFF ? hi_cnt : hi_cnt + 1'b1);
      lo_cnt <=  spi_sel_n ? '0 : (lo_cnt == 16'hFFFF ? lo_cnt : lo_cnt + 1'b1);
      oe_cnt <=  drive_ena_n ? '0 : (oe_cnt == 16'hFFFF ? oe_cnt : oe_cnt + 1'b1);
    end
    if (rst_q && !rst) begin
      a_r1_reset_state: assert (drive == '0 && !spi_miso_oe && !spi_miso);
    end
  end

  a_r2_sdo_off_deselected: assert property (@(posedge clk) disable iff (rst)
    (hi_cnt > 16'(SYNC + 2)) |-> !spi_miso_oe);

  a_r2_sdo_on_selected: assert property (@(posedge clk) disable iff (rst)
    (lo_cnt > 16'(SYNC + 2)) |-> spi_miso_oe);

  a_r5_update_when_deselected: assert property (@(posedge clk) disable iff (rst)
    !$stable(drive) |-> (drive == '0 || spi_sel_n));

  a_r9_forced_off: assert property (@(posedge clk) disable iff (rst)
    (oe_cnt > 16'(QUAL + SYNC + 2)) |-> (drive == '0));

  a_r10_no_restore_while_low: assert property (@(posedge clk) disable iff (rst)
    (oe_cnt > 16'(SYNC + 2)) |-> !(drive != '0 && $past(drive) == '0));

endmodule

bind spi_outlatch sol_chk #(.OUT_W(OUT_W), .QUAL(QUAL_CYC), .SYNC(SYNC_STAGES)) u_chk (
  .clk(clk), .rst(rst), .spi_sel_n(spi_sel_n), .drive_ena_n(drive_ena_n),
  .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe), .drive(drive)
);

// File: tb/spi_outlatch_test.sv
module spi_outlatch_test;

  localparam int H = 8;

  typedef struct packed {
    logic        m;
    logic [5:0]  n;
    logic [31:0] d;
    logic [7:0]  f;
    logic [7:0]  e;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 6'd8,  32'h0000_00A5, 8'h01, 8'hA5},
    '{1'b1, 6'd16, 32'h0000_7E3C, 8'h80, 8'h3C},
    '{1'b0, 6'd12, 32'h0000_0F69, 8'h00, 8'h69},
    '{1'b1, 6'd20, 32'h000B_1234, 8'h42, 8'h34},
    '{1'b0, 6'd8,  32'h0000_0000, 8'h5A, 8'h00},
    '{1'b1, 6'd24, 32'h00C3_FF81, 8'h00, 8'h81}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic spi_clk = 1'b0, spi_sel_n = 1'b1, spi_mosi = 1'b0, long_frame = 1'b0, drive_ena_n = 1'b1;
  logic [7:0] fault_in = '0;
  logic spi_miso, spi_miso_oe;
  logic [7:0] drive;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;
  logic [7:0] prev_f = '0, pend = '0;

  always #10 clk = ~clk;

  spi_outlatch #(.QUAL_CYC(5), .SETUP_CYC(300)) uut (
    .clk(clk), .rst(rst), .spi_clk(spi_clk), .spi_sel_n(spi_sel_n), .spi_mosi(spi_mosi),
    .long_frame(long_frame), .drive_ena_n(drive_ena_n), .fault_in(fault_in),
    .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe), .drive(drive)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rb(input logic m, input int n, input logic [31:0] d,
                                         input logic [7:0] s);
    logic [31:0] r = '0;
    int len = m ? 16 : 8;
    for (int j = 0; j < n; j++) begin
      logic b;
      if (j < len) b = (j < 8) ? s[7-j] : 1'b0;
      else         b = d[n-1-(j-len)];
      r = {r[30:0], b};
    end
    return r;
  endfunction

  task automatic frame(input logic m, input int n, input logic [31:0] d, input logic [7:0] f,
                       input string tag);
    logic [31:0] got = '0;
    logic [7:0]  s;
    fault_in = f; long_frame = m;
    repeat (4) @(negedge clk);
    s = prev_f | f | pend;
    spi_sel_n = 1'b0;
    for (int i = 0; i < n; i++) begin
      spi_mosi = d[n-1-i];
      repeat (H) @(negedge clk);
      got = {got[30:0], spi_miso};
      spi_clk = 1'b1;
      repeat (H) @(negedge clk);
      spi_clk = 1'b0;
    end
    repeat (H) @(negedge clk);
    spi_sel_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(tag, got, exp_rb(m, n, d, s));
    prev_f = f; pend = '0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      total++; bad++;
      $display("FAIL watchdog (all requirements): actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 drive after reset", drive, 0);
    chk("R1 sdo enable after reset", spi_miso_oe, 0);
    chk("R1 sdo after reset", spi_miso, 0);

    // R10: frame within setup window after reset is dropped; R1: latch empty
    frame(1'b0, 8, 32'hFF, 8'h00, "R1 empty fault latch readback");
    chk("R10 frame in setup window dropped", drive, 0);
    repeat (320) @(negedge clk);

    for (int i = 0; i < 6; i++) begin
      frame(VECS[i].m, int'(VECS[i].n), VECS[i].d, VECS[i].f, "R3/R6/R7 readback");
      chk("R5 R6 R7 drive from last bits", drive, VECS[i].e);
    end

    // R8: short frames dropped
    frame(1'b1, 10, 32'h3FF, 8'h00, "R8 readback short long-mode");
    chk("R8 short 16-bit frame dropped", drive, 8'h81);
    frame(1'b0, 5, 32'h1F, 8'h00, "R8 readback short short-mode");
    chk("R8 short 8-bit frame dropped", drive, 8'h81);

    // R2: SDO enable follows select
    @(negedge clk); spi_sel_n = 1'b0;
    repeat (6) @(negedge clk);
    chk("R2 sdo enabled while selected", spi_miso_oe, 1);
    spi_sel_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R2 sdo disabled when deselected", spi_miso_oe, 0);
    chk("R2 no-clock select leaves drive", drive, 8'h81);
    prev_f = '0;

    // R4: one-cycle fault pulse is held until the next falling edge, then cleared
    fault_in = 8'h24; @(negedge clk); fault_in = 8'h00; pend = 8'h24;
    repeat (3) @(negedge clk);
    frame(1'b0, 8, 32'h5A, 8'h00, "R4 pulse captured");
    frame(1'b0, 8, 32'hC3, 8'h00, "R4 latch cleared after copy");
    chk("R5 drive after sticky test", drive, 8'hC3);

    // R9: short enable drop ignored
    drive_ena_n = 1'b0; repeat (3) @(negedge clk); drive_ena_n = 1'b1;
    repeat (20) @(negedge clk);
    chk("R9 short enable pulse ignored", drive, 8'hC3);
    repeat (320) @(negedge clk);

    // R9/R10/R11: long enable drop
    drive_ena_n = 1'b0;
    repeat (20) @(negedge clk);
    chk("R9 outputs forced off", drive, 0);
    frame(1'b1, 16, 32'h000F, 8'h11, "R11 readback while disabled");
    chk("R10 frame while disabled dropped", drive, 0);
    drive_ena_n = 1'b1;
    repeat (20) @(negedge clk);
    chk("R10 stays off after enable high", drive, 0);
    repeat (320) @(negedge clk);
    chk("R10 stays off until new frame", drive, 0);
    held = 8'h3C;
    frame(1'b0, 8, {24'h0, held}, 8'h00, "R3 readback after re-arm");
    chk("R10 new frame restores outputs", drive, held);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule